// File: doc/BRIEF.md
# PWM Event Trigger Prescaler

This block turns time-base and compare strobes from a PWM counter into three outputs. The first is a CPU interrupt request. The other two are start-of-conversion pulses for an ADC, named A and B. Each of the three channels has its own setting for which event it follows and its own enable. It also has a 4-bit period N and a 4-bit event counter, so it raises its output on every Nth qualifying event, where N runs from 1 to 15.

The interrupt output is a sticky flag that stays high until the clear input is driven. While the flag is set, the interrupt channel does not count events, so no new request can build up. Each start-of-conversion channel gives a single-cycle pulse. A start-of-conversion channel can also be driven by a digital-compare request instead of a counter event.

Every output is registered. A qualifying strobe sampled at clock edge k shows on the output in the cycle after edge k.

Top module: `pwm_evt_trig`

## Requirements
- R1: After reset, int_req, soca_pulse and socb_pulse are low and every event counter is zero.
- R2: Event select code 1 qualifies on ev_zero. Code 2 qualifies on ev_period. Code 3 qualifies on either of the two. Code 0 never qualifies.
- R3: For compare i (0=A, 1=B, 2=C, 3=D), code 4+2i qualifies on cmp_match[i] while cnt_up is 1. Code 5+2i qualifies on cmp_match[i] while cnt_up is 0. A strobe on a different compare, or with the wrong direction, does not qualify.
- R4: With period N (1..15), a channel fires on the Nth qualifying event after its counter was last zero, and then its counter restarts from zero.
- R5: While a channel's enable is 0 or its period is 0, it never fires and its counter is held at zero. After it is re-enabled, counting starts fresh.
- R6: A start-of-conversion output is high for exactly the one cycle after the edge on which its channel fired.
- R7: int_req stays high until int_clr is sampled high. While int_req is high and int_clr is low, qualifying events are not counted by the interrupt channel.
- R8: If int_clr is sampled on the same edge as a qualifying event that completes the interrupt period, int_req stays high.
- R9: Code 12 makes channel A follow dc_soc_a and channel B follow dc_soc_b. On the interrupt channel, code 12 never qualifies. On every channel, codes 13 to 15 never qualify.
- R10: Channels A and B keep separate counters and fire independently when they are given the same events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_zero | input | 1 | Counter reached zero strobe |
| ev_period | input | 1 | Counter reached period strobe |
| cmp_match | input | 4 | Compare match strobes, bit 0 = A ... bit 3 = D |
| cnt_up | input | 1 | Count direction, 1 = counting up |
| dc_soc_a | input | 1 | Digital-compare conversion request for channel A |
| dc_soc_b | input | 1 | Digital-compare conversion request for channel B |
| int_sel | input | 4 | Interrupt event select code |
| int_en | input | 1 | Interrupt channel enable |
| int_prd | input | 4 | Interrupt event period |
| int_clr | input | 1 | Clears the interrupt flag |
| soca_sel | input | 4 | Channel A event select code |
| soca_en | input | 1 | Channel A enable |
| soca_prd | input | 4 | Channel A event period |
| socb_sel | input | 4 | Channel B event select code |
| socb_en | input | 1 | Channel B enable |
| socb_prd | input | 4 | Channel B event period |
| int_req | output | 1 | Sticky interrupt request |
| soca_pulse | output | 1 | Channel A start-of-conversion pulse |
| socb_pulse | output | 1 | Channel B start-of-conversion pulse |

## Verification
The clear of the interrupt flag and a new interrupt firing can fall on the same edge. This is the case where the two update paths of the flag meet. The bench first sets the flag with a two-event period and leaves it set. It then drives one event while the flag is set, which must not count. After a clear, the next event must not fire and the one after must fire. With the period set to one, it drives int_clr and a zero strobe together on one edge and expects int_req to still be high afterwards. A lone clear then has to drop it.

// File: rtl/evt_trig_pkg.sv
package evt_trig_pkg;
   localparam int SEL_W       = 4;
   localparam int PRD_W       = 4;
   localparam int N_CMP       = 4;
   localparam int N_CHAN      = 3;
   localparam int CH_INT      = 0;
   localparam int CH_SOCA     = 1;
   localparam int CH_SOCB     = 2;

   typedef enum logic [SEL_W-1:0] {
      EVS_OFF  = 4'd0,
      EVS_ZERO = 4'd1,
      EVS_PRD  = 4'd2,
      EVS_ZOP  = 4'd3
   } evs_fixed_e;

   localparam int EVS_CMP_BASE = 4;
   localparam int EVS_ALT      = EVS_CMP_BASE + 2*N_CMP;
endpackage

// File: rtl/evt_trig_select.sv
module evt_trig_select
   import evt_trig_pkg::*;
#(
   parameter int SW      = SEL_W,
   parameter int NC      = N_CMP,
   parameter bit USE_ALT = 1'b0
) (
   input  logic [SW-1:0] sel_i,
   input  logic          zero_i,
   input  logic          prd_i,
   input  logic [NC-1:0] cmp_i,
   input  logic          up_i,
   input  logic          alt_i,
   output logic          evt_o
);
   localparam int ALT_CODE = EVS_CMP_BASE + 2*NC;

   if (ALT_CODE >= (1 << SW)) begin : g_bad_width
      $error("evt_trig_select: select field too narrow for compare count");
   end

   logic fixed_hit;
   logic cmp_hit;
   logic alt_hit;

   always_comb begin
      case (sel_i)
         SW'(EVS_ZERO): fixed_hit = zero_i;
         SW'(EVS_PRD):  fixed_hit = prd_i;
         SW'(EVS_ZOP):  fixed_hit = zero_i | prd_i;
         default:       fixed_hit = 1'b0;
      endcase
   end

   always_comb begin
      cmp_hit = 1'b0;
      for (int i = 0; i < NC; i++) begin
         if (sel_i == SW'(EVS_CMP_BASE + 2*i) && cmp_i[i] && up_i)
            cmp_hit = 1'b1;
         if (sel_i == SW'(EVS_CMP_BASE + 2*i + 1) && cmp_i[i] && !up_i)
            cmp_hit = 1'b1;
      end
   end

   if (USE_ALT) begin : g_alt
      assign alt_hit = (sel_i == SW'(ALT_CODE)) && alt_i;
   end else begin : g_no_alt
      assign alt_hit = 1'b0;
   end

   assign evt_o = fixed_hit | cmp_hit | alt_hit;
endmodule

// File: rtl/evt_trig_prescale.sv
module evt_trig_prescale
   import evt_trig_pkg::*;
#(
   parameter int PW      = PRD_W,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic [PW-1:0] prd_i,
   input  logic          evt_i,
   input  logic          hold_i,
   output logic          fire_o
);
   if (PW < 1 || PW > 8) begin : g_bad_pw
      $error("evt_trig_prescale: period width out of range");
   end

   logic [PW-1:0] cnt_q, cnt_d;
   logic [PW:0]   cnt_inc;
   logic          active;
   logic          hit;

   assign active  = en_i && (prd_i != '0);
   assign cnt_inc = {1'b0, cnt_q} + 1'b1;

   always_comb begin
      cnt_d = cnt_q;
      hit   = 1'b0;
      if (!active) begin
         cnt_d = '0;
      end else if (evt_i && !hold_i) begin
         if (cnt_inc >= {1'b0, prd_i}) begin
            hit   = 1'b1;
            cnt_d = '0;
         end else begin
            cnt_d = cnt_inc[PW-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   if (REG_OUT) begin : g_reg
      logic fire_q;
      always_ff @(posedge clk) begin
         if (!rst_n) fire_q <= 1'b0;
         else        fire_q <= hit;
      end
      assign fire_o = fire_q;

      AST_FIRE_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
         fire_q |-> $past(evt_i && !hold_i)); // R4
      AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         !active |=> !fire_q); // R5
      AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
         fire_q |-> (cnt_q == '0)); // R4
   end else begin : g_comb
      assign fire_o = hit;
   end

   AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/pwm_evt_trig.sv
module pwm_evt_trig
   import evt_trig_pkg::*;
#(
   parameter int SW = SEL_W,
   parameter int PW = PRD_W,
   parameter int NC = N_CMP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev_zero,
   input  logic          ev_period,
   input  logic [NC-1:0] cmp_match,
   input  logic          cnt_up,
   input  logic          dc_soc_a,
   input  logic          dc_soc_b,
   input  logic [SW-1:0] int_sel,
   input  logic          int_en,
   input  logic [PW-1:0] int_prd,
   input  logic          int_clr,
   input  logic [SW-1:0] soca_sel,
   input  logic          soca_en,
   input  logic [PW-1:0] soca_prd,
   input  logic [SW-1:0] socb_sel,
   input  logic          socb_en,
   input  logic [PW-1:0] socb_prd,
   output logic          int_req,
   output logic          soca_pulse,
   output logic          socb_pulse
);
   logic [SW-1:0] ch_sel [N_CHAN];
   logic [PW-1:0] ch_prd [N_CHAN];
   logic [N_CHAN-1:0] ch_en, ch_alt, ch_evt, ch_hold, ch_fire;
   logic int_q;

   assign ch_sel[CH_INT]  = int_sel;
   assign ch_sel[CH_SOCA] = soca_sel;
   assign ch_sel[CH_SOCB] = socb_sel;
   assign ch_prd[CH_INT]  = int_prd;
   assign ch_prd[CH_SOCA] = soca_prd;
   assign ch_prd[CH_SOCB] = socb_prd;
   assign ch_en   = {socb_en, soca_en, int_en};
   assign ch_alt  = {dc_soc_b, dc_soc_a, 1'b0};
   assign ch_hold = {2'b00, int_q & ~int_clr};

   for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
      evt_trig_select #(
         .SW(SW), .NC(NC), .USE_ALT(c != CH_INT)
      ) u_sel (
         .sel_i (ch_sel[c]),
         .zero_i(ev_zero),
         .prd_i (ev_period),
         .cmp_i (cmp_match),
         .up_i  (cnt_up),
         .alt_i (ch_alt[c]),
         .evt_o (ch_evt[c])
      );
      evt_trig_prescale #(
         .PW(PW), .REG_OUT(c != CH_INT)
      ) u_pre (
         .clk   (clk),
         .rst_n (rst_n),
         .en_i  (ch_en[c]),
         .prd_i (ch_prd[c]),
         .evt_i (ch_evt[c]),
         .hold_i(ch_hold[c]),
         .fire_o(ch_fire[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  int_q <= 1'b0;
      else if (ch_fire[CH_INT])    int_q <= 1'b1;
      else if (int_clr)            int_q <= 1'b0;
   end

   assign int_req    = int_q;
   assign soca_pulse = ch_fire[CH_SOCA];
   assign socb_pulse = ch_fire[CH_SOCB];

   AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req && !int_clr) |=> int_req); // R7
   AST_INT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (int_clr && !ch_fire[CH_INT]) |=> !int_req); // R7
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ch_fire[CH_INT] |=> int_req); // R8
   AST_INT_NO_ALT: assert property (@(posedge clk) disable iff (!rst_n)
      (int_sel >= SW'(EVS_ALT)) |-> !ch_evt[CH_INT]); // R9
endmodule

// File: tb/sim_pwm_evt_trig.sv
`timescale 1ns/1ps
module sim_pwm_evt_trig;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_zero = 0, ev_period = 0, cnt_up = 0, dc_soc_a = 0, dc_soc_b = 0;
   logic [3:0] cmp_match = '0;
   logic [3:0] int_sel = '0, soca_sel = '0, socb_sel = '0;
   logic [3:0] int_prd = '0, soca_prd = '0, socb_prd = '0;
   logic int_en = 0, soca_en = 0, socb_en = 0, int_clr = 0;
   logic int_req, soca_pulse, socb_pulse;
   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   pwm_evt_trig u0 (
      .clk(clk), .rst_n(rst_n), .ev_zero(ev_zero), .ev_period(ev_period),
      .cmp_match(cmp_match), .cnt_up(cnt_up), .dc_soc_a(dc_soc_a),
      .dc_soc_b(dc_soc_b), .int_sel(int_sel), .int_en(int_en),
      .int_prd(int_prd), .int_clr(int_clr), .soca_sel(soca_sel),
      .soca_en(soca_en), .soca_prd(soca_prd), .socb_sel(socb_sel),
      .socb_en(socb_en), .socb_prd(socb_prd), .int_req(int_req),
      .soca_pulse(soca_pulse), .socb_pulse(socb_pulse)
   );

   // {sel[3:0], zero, period, cmp[3:0], up, dc_a, expected}
   localparam int NV = 18;
   localparam logic [12:0] VEC [NV] = '{
      {4'd1,  1'b1,1'b0,4'b0000,1'b0,1'b0,1'b1},
      {4'd1,  1'b0,1'b1,4'b0000,1'b0,1'b0,1'b0},
      {4'd2,  1'b0,1'b1,4'b0000,1'b0,1'b0,1'b1},
      {4'd3,  1'b1,1'b0,4'b0000,1'b0,1'b0,1'b1},
      {4'd3,  1'b0,1'b1,4'b0000,1'b0,1'b0,1'b1},
      {4'd3,  1'b0,1'b0,4'b1111,1'b1,1'b1,1'b0},
      {4'd4,  1'b0,1'b0,4'b0001,1'b1,1'b0,1'b1},
      {4'd4,  1'b0,1'b0,4'b0001,1'b0,1'b0,1'b0},
      {4'd5,  1'b0,1'b0,4'b0001,1'b0,1'b0,1'b1},
      {4'd6,  1'b0,1'b0,4'b0010,1'b1,1'b0,1'b1},
      {4'd7,  1'b0,1'b0,4'b0001,1'b0,1'b0,1'b0},
      {4'd9,  1'b0,1'b0,4'b0100,1'b0,1'b0,1'b1},
      {4'd10, 1'b0,1'b0,4'b1000,1'b1,1'b0,1'b1},
      {4'd11, 1'b0,1'b0,4'b1000,1'b1,1'b0,1'b0},
      {4'd12, 1'b0,1'b0,4'b0000,1'b0,1'b1,1'b1},
      {4'd12, 1'b1,1'b1,4'b1111,1'b1,1'b0,1'b0},
      {4'd0,  1'b1,1'b1,4'b1111,1'b1,1'b1,1'b0},
      {4'd13, 1'b1,1'b1,4'b1111,1'b1,1'b1,1'b0}
   };

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      ev_zero = 0; ev_period = 0; cmp_match = '0; dc_soc_a = 0; dc_soc_b = 0; int_clr = 0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(int_req, 1'b0, "R1", "int_req in reset");
      chk(soca_pulse, 1'b0, "R1", "soca in reset");
      rst_n = 1;
      tick();
      chk(socb_pulse, 1'b0, "R1", "socb after reset");

      // event decoding table, channel A with period 1
      soca_en = 1; soca_prd = 4'd1;
      for (int i = 0; i < NV; i++) begin
         string rq;
         soca_sel  = VEC[i][12:9];
         ev_zero   = VEC[i][8];
         ev_period = VEC[i][7];
         cmp_match = VEC[i][6:3];
         cnt_up    = VEC[i][2];
         dc_soc_a  = VEC[i][1];
         rq = (VEC[i][12:9] <= 4'd3 && VEC[i][12:9] != 4'd0) ? "R2" :
              (VEC[i][12:9] >= 4'd12 || VEC[i][12:9] == 4'd0) ? "R9" : "R3";
         if (VEC[i][12:9] == 4'd0) rq = "R2";
         tick();
         chk(soca_pulse, VEC[i][0], rq, $sformatf("vector %0d", i));
      end
      tick();
      chk(soca_pulse, 1'b0, "R6", "pulse lasts one cycle");

      // R4: channel B every third zero event, period strobes ignored
      soca_en = 0; socb_sel = 4'd1; socb_prd = 4'd3; socb_en = 1;
      for (int k = 1; k <= 6; k++) begin
         ev_period = 1; tick();
         chk(socb_pulse, 1'b0, "R4", "non-qualifying strobe");
         ev_zero = 1; tick();
         chk(socb_pulse, (k % 3) == 0, "R4", $sformatf("zero event %0d", k));
      end

      // R5: partial count cleared by disable
      ev_zero = 1; tick();
      ev_zero = 1; tick();
      socb_en = 0; ev_zero = 1; tick();
      chk(socb_pulse, 1'b0, "R5", "disabled channel silent");
      socb_en = 1;
      ev_zero = 1; tick();
      ev_zero = 1; tick();
      chk(socb_pulse, 1'b0, "R5", "count restarted after re-enable");
      ev_zero = 1; tick();
      chk(socb_pulse, 1'b1, "R5", "third event after re-enable");
      socb_prd = 4'd0;
      ev_zero = 1; tick();
      chk(socb_pulse, 1'b0, "R5", "period zero silent");

      // R10: A every 2nd, B every 3rd on shared events
      soca_sel = 4'd1; soca_prd = 4'd2; soca_en = 1; socb_prd = 4'd3;
      tick();
      for (int k = 1; k <= 6; k++) begin
         ev_zero = 1; tick();
         chk(soca_pulse, (k % 2) == 0, "R10", $sformatf("A event %0d", k));
         chk(socb_pulse, (k % 3) == 0, "R10", $sformatf("B event %0d", k));
      end
      soca_en = 0; socb_en = 0;

      // R7: sticky flag and frozen count
      int_sel = 4'd2; int_prd = 4'd2; int_en = 1;
      ev_period = 1; tick();
      chk(int_req, 1'b0, "R7", "first of two events");
      ev_period = 1; tick();
      chk(int_req, 1'b1, "R7", "second event sets flag");
      tick();
      chk(int_req, 1'b1, "R7", "flag held");
      ev_period = 1; tick();
      int_clr = 1; tick();
      chk(int_req, 1'b0, "R7", "clear drops flag");
      ev_period = 1; tick();
      chk(int_req, 1'b0, "R7", "event while set was not counted");
      ev_period = 1; tick();
      chk(int_req, 1'b1, "R7", "flag after two fresh events");

      // R8: clear and fire on the same edge
      int_sel = 4'd1; int_prd = 4'd1;
      int_clr = 1; ev_zero = 1; tick();
      chk(int_req, 1'b1, "R8", "set wins over clear");
      int_clr = 1; tick();
      chk(int_req, 1'b0, "R8", "lone clear");

      // R9: digital-compare code ignored on interrupt channel
      int_sel = 4'd12;
      dc_soc_a = 1; dc_soc_b = 1; ev_zero = 1; cmp_match = 4'hF; tick();
      chk(int_req, 1'b0, "R9", "code 12 on interrupt");

      summary();
      $finish;
   end
endmodule